// File: doc/BRIEF.md
# Reset Boot-Vector Overlay Address Decoder

This block decodes the 16-bit data bus of a processor board with a 24-bit byte address space and separate upper and lower byte strobes. It turns each bus cycle into a chip select for main RAM, for the system ROM or for the four byte registers of a dual-channel serial controller, and it steers the read data back onto the bus. When nothing answers a read, the bus sees all ones.

After reset the processor fetches its initial stack pointer and program counter from the bottom eight bytes of the address space. Until the first write, those eight bytes show the first four words of the system ROM. Any write into that window switches it to a small four-word RAM held inside the decoder, and it stays that way until the next reset. Writes into this RAM merge under the byte strobes. The decode is combinational and adds no wait states. Only the overlay state is registered.

Top module: `bootmap_decoder`

## Requirements
- R1: After reset, a read of byte addresses 0x000000 to 0x000007 asserts rom_cs with rom_addr equal to the word index inside the window (0 to 3). The bus returns that ROM word.
- R2: A write with at least one strobe into the window switches the window to the internal four-word RAM. The write itself lands in that RAM. From the next cycle on, reads of the window return the RAM contents, and neither rom_cs nor ram_cs is asserted for window accesses.
- R3: A write into the window RAM changes only the byte lanes whose strobe is set. bus_be[1] enables D15:D8 and bus_be[0] enables D7:D0.
- R4: Once switched, the window stays in RAM mode whatever other traffic follows. Only reset returns it to the ROM mirror.
- R5: Byte addresses 0x000008 to 0x1FFFFF assert ram_cs, with ram_addr equal to byte address bits 20:1. ram_we follows the bus write flag. Reads return ram_rdata.
- R6: Byte addresses 0xFC0000 to 0xFDFFFF assert rom_cs on reads only, with rom_addr equal to byte address bits 16:1. A write there selects nothing.
- R7: Byte addresses 0xFEA000, 0xFEA002, 0xFEA004 and 0xFEA006 assert ser_cs with ser_reg = 0, 1, 2, 3 (channel A control, channel B control, channel A data, channel B data), but only when the upper strobe is set. Reads return ser_rdata on D15:D8 and 0xFF on D7:D0. Writes present D15:D8 on ser_wdata with ser_we set.
- R8: A read that selects nothing returns 0xFFFF. This covers unmapped space and a serial access made with only the lower strobe.
- R9: A cycle with both strobes clear selects nothing, and a write of that kind does not switch the window.
- R10: At most one of RAM, ROM, serial controller and window RAM is selected in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_addr | input | 23 | Word address, byte address bits 23:1 |
| bus_we | input | 1 | 1 for write cycle, 0 for read |
| bus_be | input | 2 | Byte strobes, bit 1 = D15:D8, bit 0 = D7:D0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data returned to the processor |
| ram_cs | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write |
| ram_addr | output | 20 | Main RAM word address |
| ram_rdata | input | 16 | Main RAM read data |
| rom_cs | output | 1 | System ROM select (reads only) |
| rom_addr | output | 16 | System ROM word offset |
| rom_rdata | input | 16 | System ROM read data |
| ser_cs | output | 1 | Serial controller select |
| ser_we | output | 1 | Serial controller write |
| ser_reg | output | 2 | Serial register: 0 A ctrl, 1 B ctrl, 2 A data, 3 B data |
| ser_wdata | output | 8 | Serial write byte (bus D15:D8) |
| ser_rdata | input | 8 | Serial read byte |

## Verification
The assertions assume that address, write flag and strobes stay steady from one clock edge to the next, and that a cycle with no strobe is idle whatever the address says. The bench holds to this. It drives every access on the falling edge, samples the combinational selects and read data just before the rising edge, and returns the strobes to zero between accesses. The merge check on the window RAM assumes a word is written in full before it is read. The bench therefore writes each overlay word completely before it applies partial-strobe writes or reads it back.

// File: rtl/bootmap_pkg.sv
`timescale 1ns/1ps
package bootmap_pkg;

  // Address regions seen by the decoder
  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_WIN,
    RGN_RAM,
    RGN_ROM,
    RGN_SER
  } region_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/bootmap_region.sv
`timescale 1ns/1ps
module bootmap_region
  import bootmap_pkg::*;
#(
  parameter int WA        = 23,
  parameter int WIN_WORDS = 4,
  parameter int RAM_WORDS = 1048576,
  parameter int ROM_LO    = 8257536,
  parameter int ROM_WORDS = 65536,
  parameter int SER_LO    = 8343552,
  parameter int SER_REGS  = 4
) (
  input  logic [WA-1:0] word_addr,
  output region_e       region
);

  localparam logic [WA:0] WIN_END = (WA+1)'(WIN_WORDS);
  localparam logic [WA:0] RAM_END = (WA+1)'(RAM_WORDS);
  localparam logic [WA:0] ROM_BEG = (WA+1)'(ROM_LO);
  localparam logic [WA:0] ROM_END = (WA+1)'(ROM_LO + ROM_WORDS);
  localparam logic [WA:0] SER_BEG = (WA+1)'(SER_LO);
  localparam logic [WA:0] SER_END = (WA+1)'(SER_LO + SER_REGS);

  logic [WA:0] wa_ext;

  always_comb begin
    wa_ext = {1'b0, word_addr};
    if (wa_ext < WIN_END) begin
      region = RGN_WIN;
    end else if (wa_ext < RAM_END) begin
      region = RGN_RAM;
    end else if (wa_ext >= ROM_BEG && wa_ext < ROM_END) begin
      region = RGN_ROM;
    end else if (wa_ext >= SER_BEG && wa_ext < SER_END) begin
      region = RGN_SER;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/bootmap_window.sv
`timescale 1ns/1ps
module bootmap_window
  import bootmap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [IW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              active,
  output logic [DATA_W-1:0] rd_word
);

  logic              flag_q;
  logic              flag_d;
  logic [DATA_W-1:0] mem_q [WORDS];

  // next state of the overlay flag: set by a window write, held until reset
  always_comb begin
    flag_d = flag_q | wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  // per-word, per-lane write enables
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic lane_en;
      always_comb begin
        lane_en = wr_en && be[l] && (idx == IW'(w));
      end
      always_ff @(posedge clk) begin
        if (lane_en) begin
          mem_q[w][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  always_comb begin
    active  = flag_q;
    rd_word = mem_q[idx];
  end

  // once in RAM mode, the window stays there until reset
  assert_window_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);

  // the switch happens only after a write into the window
  assert_window_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wr_en));

  // a strobed lane takes the written byte
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[l]) |=>
        (mem_q[$past(idx)][l*BYTE_W +: BYTE_W] == $past(wdata[l*BYTE_W +: BYTE_W])));
  end

endmodule

// File: rtl/bootmap_rdmux.sv
`timescale 1ns/1ps
module bootmap_rdmux
  import bootmap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SER_LANE = 1,
  localparam int LANES   = DATA_W / BYTE_W
) (
  input  logic              sel_ram,
  input  logic              sel_rom,
  input  logic              sel_ser,
  input  logic              sel_win,
  input  logic [DATA_W-1:0] ram_data,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [BYTE_W-1:0] ser_data,
  input  logic [DATA_W-1:0] win_data,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ser_word;

  // the serial byte rides on its own lane, the others float high
  for (genvar l = 0; l < LANES; l++) begin : g_ser_lane
    if (l == SER_LANE) begin : g_live
      always_comb ser_word[l*BYTE_W +: BYTE_W] = ser_data;
    end else begin : g_idle
      always_comb ser_word[l*BYTE_W +: BYTE_W] = '1;
    end
  end

  always_comb begin
    if (sel_win) begin
      rdata = win_data;
    end else if (sel_ram) begin
      rdata = ram_data;
    end else if (sel_rom) begin
      rdata = rom_data;
    end else if (sel_ser) begin
      rdata = ser_word;
    end else begin
      rdata = '1;
    end
  end

endmodule

// File: rtl/bootmap_decoder.sv
`timescale 1ns/1ps
module bootmap_decoder
  import bootmap_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int WIN_WORDS = 4,
  parameter int RAM_BYTES = 2097152,
  parameter int ROM_BASE  = 32'hFC0000,
  parameter int ROM_BYTES = 131072,
  parameter int SER_BASE  = 32'hFEA000,
  parameter int SER_REGS  = 4,
  parameter int SER_LANE  = 1,
  localparam int LANES    = DATA_W / BYTE_W,
  localparam int BYTE_SH  = $clog2(LANES),
  localparam int WA       = ADDR_W - BYTE_SH,
  localparam int RAM_AW   = $clog2(RAM_BYTES / LANES),
  localparam int ROM_AW   = $clog2(ROM_BYTES / LANES),
  localparam int SER_IW   = $clog2(SER_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WA-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              ser_cs,
  output logic              ser_we,
  output logic [SER_IW-1:0] ser_reg,
  output logic [BYTE_W-1:0] ser_wdata,
  input  logic [BYTE_W-1:0] ser_rdata
);

  localparam int WIN_IW    = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
  localparam int RAM_WORDS = RAM_BYTES / LANES;
  localparam int ROM_WORDS = ROM_BYTES / LANES;
  localparam int ROM_LO    = ROM_BASE / LANES;
  localparam int SER_LO    = SER_BASE / LANES;

  // reset: asserted at once, released through two flops
  logic rst_meta_q;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  region_e           region;
  logic              any_be;
  logic              win_hit;
  logic              win_wr;
  logic              win_sel;
  logic              win_mirror;
  logic              win_active;
  logic [DATA_W-1:0] win_rdata;

  bootmap_region #(
    .WA        (WA),
    .WIN_WORDS (WIN_WORDS),
    .RAM_WORDS (RAM_WORDS),
    .ROM_LO    (ROM_LO),
    .ROM_WORDS (ROM_WORDS),
    .SER_LO    (SER_LO),
    .SER_REGS  (SER_REGS)
  ) u_region (
    .word_addr (bus_addr),
    .region    (region)
  );

  always_comb begin
    any_be     = |bus_be;
    win_hit    = (region == RGN_WIN);
    win_wr     = win_hit && any_be && bus_we;
    win_sel    = win_hit && any_be && (win_active || bus_we);
    win_mirror = win_hit && any_be && !win_active && !bus_we;

    ram_cs   = any_be && (region == RGN_RAM);
    ram_we   = ram_cs && bus_we;
    ram_addr = bus_addr[RAM_AW-1:0];

    rom_cs = win_mirror || (any_be && !bus_we && (region == RGN_ROM));
    if (region == RGN_ROM) begin
      rom_addr = bus_addr[ROM_AW-1:0];
    end else begin
      rom_addr = ROM_AW'(bus_addr[WIN_IW-1:0]);
    end

    ser_cs    = bus_be[SER_LANE] && (region == RGN_SER);
    ser_we    = ser_cs && bus_we;
    ser_reg   = bus_addr[SER_IW-1:0];
    ser_wdata = bus_wdata[SER_LANE*BYTE_W +: BYTE_W];
  end

  bootmap_window #(
    .DATA_W (DATA_W),
    .WORDS  (WIN_WORDS)
  ) u_window (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (win_wr),
    .be      (bus_be),
    .idx     (bus_addr[WIN_IW-1:0]),
    .wdata   (bus_wdata),
    .active  (win_active),
    .rd_word (win_rdata)
  );

  bootmap_rdmux #(
    .DATA_W   (DATA_W),
    .SER_LANE (SER_LANE)
  ) u_rdmux (
    .sel_ram  (ram_cs),
    .sel_rom  (rom_cs),
    .sel_ser  (ser_cs),
    .sel_win  (win_sel),
    .ram_data (ram_rdata),
    .rom_data (rom_rdata),
    .ser_data (ser_rdata),
    .win_data (win_rdata),
    .rdata    (bus_rdata)
  );

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ram_cs, rom_cs, ser_cs, win_sel}));

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_be == '0) |-> !(ram_cs || rom_cs || ser_cs || win_sel));

  assert_rom_readonly_R6: assert property (@(posedge clk) disable iff (!rst_q)
    rom_cs |-> !bus_we);

  assert_ser_lane_R7: assert property (@(posedge clk) disable iff (!rst_q)
    ser_cs |-> bus_be[SER_LANE]);

  assert_unmapped_ones_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (!bus_we && !(ram_cs || rom_cs || ser_cs || win_sel)) |-> (bus_rdata == '1));

  assert_win_mirror_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (win_hit && !win_active && !bus_we && any_be) |->
      (rom_cs && rom_addr == ROM_AW'(bus_addr[WIN_IW-1:0])));

  assert_win_no_ext_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (win_hit && win_active) |-> !(rom_cs || ram_cs));

endmodule

// File: tb/sim_bootmap_decoder.sv
`timescale 1ns/1ps
module sim_bootmap_decoder;

  logic        clk;
  logic        rst_n;
  logic [22:0] bus_addr;
  logic        bus_we;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ram_cs, ram_we;
  logic [19:0] ram_addr;
  logic [15:0] ram_rdata;
  logic        rom_cs;
  logic [15:0] rom_addr;
  logic [15:0] rom_rdata;
  logic        ser_cs, ser_we;
  logic [1:0]  ser_reg;
  logic [7:0]  ser_wdata;
  logic [7:0]  ser_rdata;

  int total;
  int bad;

  bootmap_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ser_cs(ser_cs), .ser_we(ser_we), .ser_reg(ser_reg),
    .ser_wdata(ser_wdata), .ser_rdata(ser_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural memories
  function automatic logic [15:0] rom_fn(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  function automatic logic [7:0] ser_fn(input logic [1:0] r);
    return 8'h90 | {6'b0, r};
  endfunction

  logic [15:0] tram [64];
  logic [1:0]  cap_reg;
  logic [7:0]  cap_dat;
  int          cap_n;

  assign rom_rdata = rom_fn(rom_addr);
  assign ram_rdata = tram[ram_addr[5:0]];
  assign ser_rdata = ser_fn(ser_reg);

  always @(posedge clk) begin
    if (ram_cs && ram_we) begin
      if (bus_be[1]) tram[ram_addr[5:0]][15:8] <= bus_wdata[15:8];
      if (bus_be[0]) tram[ram_addr[5:0]][7:0]  <= bus_wdata[7:0];
    end
    if (ser_cs && ser_we) begin
      cap_reg <= ser_reg;
      cap_dat <= ser_wdata;
      cap_n   <= cap_n + 1;
    end
  end

  // sampled outputs of the last access
  logic [15:0] s_rd;
  logic        s_ram, s_ramwe, s_rom, s_ser, s_serwe;
  logic [19:0] s_ramaddr;
  logic [15:0] s_romaddr;
  logic [1:0]  s_serreg;
  logic [7:0]  s_serwd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [23:0] a, input logic we, input logic [1:0] be,
                     input logic [15:0] wd);
    @(negedge clk);
    bus_addr  = a[23:1];
    bus_we    = we;
    bus_be    = be;
    bus_wdata = wd;
    #1;
    s_rd      = bus_rdata;
    s_ram     = ram_cs;
    s_ramwe   = ram_we;
    s_ramaddr = ram_addr;
    s_rom     = rom_cs;
    s_romaddr = rom_addr;
    s_ser     = ser_cs;
    s_serwe   = ser_we;
    s_serreg  = ser_reg;
    s_serwd   = ser_wdata;
    @(posedge clk);
    #1;
    bus_be = 2'b00;
    bus_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    bus_be = 2'b00;
    bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset_mirror();
    acc(24'h000000, 1'b0, 2'b11, 16'h0);
    chk("R1 rom_cs at 0x0", s_rom, 1);
    chk("R1 rom_addr at 0x0", s_romaddr, 0);
    chk("R1 data at 0x0", s_rd, rom_fn(16'd0));
    chk("R1 no ram_cs at 0x0", s_ram, 0);
    acc(24'h000006, 1'b0, 2'b10, 16'h0);
    chk("R1 rom_addr at 0x6", s_romaddr, 3);
    chk("R1 data at 0x6", s_rd, rom_fn(16'd3));
  endtask

  task automatic t_rom();
    acc(24'hFC0000, 1'b0, 2'b11, 16'h0);
    chk("R6 rom_cs base", s_rom, 1);
    chk("R6 rom data base", s_rd, rom_fn(16'd0));
    acc(24'hFDFFFE, 1'b0, 2'b01, 16'h0);
    chk("R6 rom_addr top", s_romaddr, 16'hFFFF);
    chk("R6 rom data top", s_rd, rom_fn(16'hFFFF));
    acc(24'hFC0010, 1'b1, 2'b11, 16'h1234);
    chk("R6 write selects nothing", {s_rom, s_ram, s_ser}, 0);
    acc(24'hFE0000, 1'b0, 2'b11, 16'h0);
    chk("R8 above rom reads ones", s_rd, 16'hFFFF);
  endtask

  task automatic t_ram();
    acc(24'h000008, 1'b1, 2'b11, 16'h1234);
    chk("R5 ram_cs write", s_ram, 1);
    chk("R5 ram_we", s_ramwe, 1);
    chk("R5 ram_addr", s_ramaddr, 4);
    acc(24'h000008, 1'b1, 2'b10, 16'hABFF);
    acc(24'h000008, 1'b0, 2'b11, 16'h0);
    chk("R5 ram read after upper write", s_rd, 16'hAB34);
    chk("R5 ram_we low on read", s_ramwe, 0);
    acc(24'h1FFFFE, 1'b0, 2'b11, 16'h0);
    chk("R5 ram top select", {s_ram, s_ramaddr}, {1'b1, 20'hFFFFF});
    acc(24'h200000, 1'b0, 2'b11, 16'h0);
    chk("R8 above ram reads ones", {s_ram, s_rd}, {1'b0, 16'hFFFF});
  endtask

  task automatic t_serial();
    for (int r = 0; r < 4; r++) begin
      acc(24'hFEA000 + 24'(2 * r), 1'b0, 2'b11, 16'h0);
      chk("R7 ser_cs", s_ser, 1);
      chk("R7 ser_reg", s_serreg, r);
      chk("R7 ser read word", s_rd, {ser_fn(2'(r)), 8'hFF});
    end
    acc(24'hFEA004, 1'b1, 2'b10, 16'h5A00);
    chk("R7 ser_we", s_serwe, 1);
    chk("R7 captured reg", cap_reg, 2);
    chk("R7 captured byte", cap_dat, 8'h5A);
    acc(24'hFEA002, 1'b0, 2'b01, 16'h0);
    chk("R8 ser lower strobe only", {s_ser, s_rd}, {1'b0, 16'hFFFF});
    acc(24'hFEA008, 1'b0, 2'b11, 16'h0);
    chk("R8 past serial regs", {s_ser, s_rd}, {1'b0, 16'hFFFF});
  endtask

  task automatic t_no_strobe();
    acc(24'h000010, 1'b0, 2'b00, 16'h0);
    chk("R9 no select ram", {s_ram, s_rom, s_ser}, 0);
    acc(24'hFC0000, 1'b0, 2'b00, 16'h0);
    chk("R9 no select rom", {s_ram, s_rom, s_ser}, 0);
    acc(24'hFEA000, 1'b1, 2'b00, 16'h0);
    chk("R9 no select ser", {s_ram, s_rom, s_ser}, 0);
    acc(24'h000000, 1'b1, 2'b00, 16'hDEAD);
    acc(24'h000000, 1'b0, 2'b11, 16'h0);
    chk("R9 strobeless write leaves mirror", {s_rom, s_rd}, {1'b1, rom_fn(16'd0)});
  endtask

  task automatic t_overlay();
    acc(24'h000002, 1'b1, 2'b11, 16'hBEEF);
    chk("R2 first write no ext select", {s_ram, s_rom}, 0);
    acc(24'h000002, 1'b0, 2'b11, 16'h0);
    chk("R2 read overlay", s_rd, 16'hBEEF);
    chk("R2 rom not selected", s_rom, 0);
    acc(24'h000000, 1'b1, 2'b11, 16'h1111);
    acc(24'h000000, 1'b1, 2'b10, 16'h22FF);
    acc(24'h000000, 1'b0, 2'b11, 16'h0);
    chk("R3 upper lane merge", s_rd, 16'h2211);
    acc(24'h000000, 1'b1, 2'b01, 16'hFF33);
    acc(24'h000000, 1'b0, 2'b11, 16'h0);
    chk("R3 lower lane merge", s_rd, 16'h2233);
    acc(24'h000006, 1'b1, 2'b11, 16'h7777);
    acc(24'h000006, 1'b0, 2'b11, 16'h0);
    chk("R2 overlay word 3", s_rd, 16'h7777);
    acc(24'hFC0006, 1'b0, 2'b11, 16'h0);
    chk("R2 rom unchanged", s_rd, rom_fn(16'd3));
  endtask

  task automatic t_persist();
    acc(24'h000100, 1'b1, 2'b11, 16'h4242);
    acc(24'hFEA000, 1'b0, 2'b10, 16'h0);
    acc(24'hFC0000, 1'b0, 2'b11, 16'h0);
    acc(24'h000002, 1'b0, 2'b11, 16'h0);
    chk("R4 overlay kept", {s_rom, s_rd}, {1'b0, 16'hBEEF});
    do_reset();
    acc(24'h000002, 1'b0, 2'b11, 16'h0);
    chk("R4 reset restores mirror", {s_rom, s_romaddr, s_rd}, {1'b1, 16'd1, rom_fn(16'd1)});
  endtask

  task automatic t_onehot_sweep();
    logic [23:0] addrs [6];
    addrs[0] = 24'h000000; addrs[1] = 24'h000008; addrs[2] = 24'hFC0000;
    addrs[3] = 24'hFEA006; addrs[4] = 24'hFFFFFE; addrs[5] = 24'h000004;
    for (int i = 0; i < 6; i++) begin
      acc(addrs[i], 1'b0, 2'b11, 16'h0);
      chk("R10 at most one select", ($countones({s_ram, s_rom, s_ser}) <= 1), 1);
    end
  endtask

  initial begin
    total = 0;
    bad = 0;
    cap_n = 0;
    rst_n = 1'b0;
    bus_addr = '0;
    bus_we = 1'b0;
    bus_be = 2'b00;
    bus_wdata = '0;
    do_reset();
    t_reset_mirror();
    t_rom();
    t_ram();
    t_serial();
    t_no_strobe();
    t_onehot_sweep();
    t_overlay();
    t_persist();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog all-requirements act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule